// File: doc/BRIEF.md
# RC Pulse-Width Capture Ring Logger

This block measures the waveform on one receiver pin, typically a servo or pulse-position stream from a radio receiver. The pin is brought into the clock domain through a synchroniser. An interval counter then times each low phase and each high phase in clock ticks. The counter restarts at every transition, so every captured value is a duration, not a time of day. At 200 MHz one tick is 5 ns.

Once a full low-then-high pair is known, it is stored as one record of two words in a circular buffer. The buffer holds `DEPTH` records, 300 by default. A producer index (tail) marks the slot that will be filled next. A consumer index (head) belongs to the host: the host reads records through a plain synchronous port and writes head back to show how far it has read. The block never interprets the pulses as channel values.

Top module: `pulse_ring_logger`

## Requirements
- R1: After a synchronous active-low reset, rdata is 0, and head, tail and every word of every record read as zero.
- R2: The pin passes through a two-flop synchroniser. An edge acts on the capture logic two clocks after it is sampled. Edges as close as one clock apart are each timed correctly.
- R3: Capture starts with the first falling edge after reset. Any rising edge seen before that edge is ignored and stores nothing.
- R4: A record holds the low interval (falling edge to rising edge) in its first word and the high interval (rising edge to the next falling edge) in its second word. The falling edge that ends the high phase completes the record, and timing then continues with the next low phase.
- R5: Each interval counts clocks from the previous synchronised edge to the current one. The counter restarts at every edge, so a value never includes earlier phases.
- R6: If no edge arrives before the counter reaches all-ones (2^CNT_W-1), the counter holds that value, and the value stored is all-ones.
- R7: The first word of a record is written one clock after the completing edge. The second word is written, and tail advances, one clock after that. A slot that has never been filled reads as zero until tail has passed it.
- R8: Tail counts up from 0. From DEPTH-1 it wraps to 0, and new records then overwrite the oldest ones.
- R9: Read map: address 0 returns head and address 1 returns tail, each zero-extended. Address 2+2k returns the low word of record k and 3+2k returns its high word. Any other address returns 0. rdata is registered and reflects the address presented one clock earlier.
- R10: A write to address 0 loads head from host_wdata. A write to any other address has no effect on tail, head or the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of interval counting |
| rst_n | input | 1 | Synchronous reset, active low |
| pulse_in | input | 1 | Asynchronous receiver pulse stream |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W ($clog2(2*DEPTH+2), 10 by default) | Host word address |
| host_wdata | input | IDX_W (16) | Host write data (new head value) |
| host_rdata | output | 32 | Registered host read data |

## Verification
Most internal state in this block shows up at the read port within a few clocks. A fault in the synchroniser or in the counter gives a stored interval that is off by a fixed amount. A wrong arming or phase state swaps the two words of a record or drops a record. A fault in the write sequencing or in the wrap logic moves tail at the wrong time or fills the wrong slot. The bench cycles the read address through every location, out-of-range ones included, while pulses arrive, and it compares rdata with a behavioural model on every clock. Because of this sweep, a divergence is reported within one address sweep, about sixteen clocks, after the state goes wrong.

// File: rtl/pulse_ring_pkg.sv
// Shared types and constants for the pulse ring logger.
package pulse_ring_pkg;
    localparam int DATA_W = 32;

    // Capture phase sequence: arm on falling edge, then alternate.
    typedef enum logic [1:0] {
        CAP_ARM,
        CAP_WAIT_RISE,
        CAP_WAIT_FALL
    } cap_state_e;

    // Two-word record write sequence.
    typedef enum logic [1:0] {
        WR_IDLE,
        WR_LO,
        WR_HI
    } wr_step_e;
endpackage

// File: rtl/pulse_ring_sync_edge.sv
// Synchronises an asynchronous pin and flags its rising and falling edges.
// Assumes STAGES >= 2; edge flags are single-cycle and refer to the synced level.
module pulse_ring_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    // sync_chain[STAGES-1] is the synchronised level, sync_chain[STAGES] its previous value
    logic [STAGES:0] sync_chain;

    // Shift the pin through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_chain <= '0;
        else        sync_chain <= {sync_chain[STAGES-1:0], din};
    end

    assign rise =  sync_chain[STAGES-1] & ~sync_chain[STAGES];
    assign fall = ~sync_chain[STAGES-1] &  sync_chain[STAGES];
endmodule

// File: rtl/pulse_ring_interval.sv
// Difference-mode interval timer: counts clocks since the last edge,
// restarting at every edge and saturating at all-ones. Pairs a low interval
// with the following high interval and offers the pair on rec_valid.
// Assumes rise and fall are never asserted together.
module pulse_ring_interval
    import pulse_ring_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    output logic             rec_valid,
    output logic [CNT_W-1:0] rec_lo,
    output logic [CNT_W-1:0] rec_hi
);
    cap_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lo_q;

    // Interval counter: restart at 1 on an edge, otherwise climb until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (rise || fall)   cnt_q <= CNT_W'(1);
        else if (cnt_q != '1)    cnt_q <= cnt_q + CNT_W'(1);
    end

    // Phase tracker: arm on the first fall, then latch the low interval at each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_ARM;
            lo_q    <= '0;
        end else begin
            unique case (state_q)
                CAP_ARM:       if (fall) state_q <= CAP_WAIT_RISE;
                CAP_WAIT_RISE: if (rise) begin
                                   lo_q    <= cnt_q;
                                   state_q <= CAP_WAIT_FALL;
                               end
                CAP_WAIT_FALL: if (fall) state_q <= CAP_WAIT_RISE;
                default:       state_q <= CAP_ARM;
            endcase
        end
    end

    assign rec_valid = (state_q == CAP_WAIT_FALL) && fall;
    assign rec_lo    = lo_q;
    assign rec_hi    = cnt_q;
endmodule

// File: rtl/pulse_ring_store.sv
// Circular record store with host access. Writes each record as two words on
// consecutive clocks, then marks the slot filled and advances tail. Reads are
// registered; unfilled slots and unmapped addresses read as zero.
// Assumes a new record never arrives while the low word is being written.
module pulse_ring_store
    import pulse_ring_pkg::*;
#(
    parameter int DEPTH  = 300,
    parameter int CNT_W  = 32,
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [CNT_W-1:0]  rec_lo,
    input  logic [CNT_W-1:0]  rec_hi,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [IDX_W-1:0]  host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0]  lo_mem [DEPTH];
    logic [CNT_W-1:0]  hi_mem [DEPTH];
    logic [DEPTH-1:0]  filled_q;
    logic [CNT_W-1:0]  pend_lo_q, pend_hi_q;
    wr_step_e          wstep;
    logic [IDX_W-1:0]  tail_q, head_q;
    logic [ADDR_W-1:0] ent;
    logic              ent_ok;

    assign ent    = ADDR_W'((host_addr - ADDR_W'(2)) >> 1);
    assign ent_ok = (host_addr >= ADDR_W'(2)) && (ent < ADDR_W'(DEPTH));

    // Storage writes: low word first, high word on the following clock.
    always_ff @(posedge clk) begin
        if (wstep == WR_LO) lo_mem[tail_q[ENT_W-1:0]] <= pend_lo_q;
        if (wstep == WR_HI) hi_mem[tail_q[ENT_W-1:0]] <= pend_hi_q;
    end

    // Sequencer: hold the pending pair, step through the write, publish via tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled_q  <= '0;
            pend_lo_q <= '0;
            pend_hi_q <= '0;
            wstep     <= WR_IDLE;
            tail_q    <= '0;
        end else begin
            if (wstep == WR_HI) begin
                filled_q[tail_q[ENT_W-1:0]] <= 1'b1;
                tail_q <= (tail_q == IDX_W'(DEPTH - 1)) ? '0 : tail_q + IDX_W'(1);
            end
            if (rec_valid) begin
                pend_lo_q <= rec_lo;
                pend_hi_q <= rec_hi;
                wstep     <= WR_LO;
            end else begin
                unique case (wstep)
                    WR_LO:   wstep <= WR_HI;
                    default: wstep <= WR_IDLE;
                endcase
            end
        end
    end

    // Consumer index: written only by the host at address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 head_q <= '0;
        else if (host_we && host_addr == '0)        head_q <= host_wdata;
    end

    // Registered read decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_addr == '0) begin
            host_rdata <= DATA_W'(head_q);
        end else if (host_addr == ADDR_W'(1)) begin
            host_rdata <= DATA_W'(tail_q);
        end else if (ent_ok && filled_q[ent[ENT_W-1:0]]) begin
            host_rdata <= host_addr[0] ? DATA_W'(hi_mem[ent[ENT_W-1:0]])
                                       : DATA_W'(lo_mem[ent[ENT_W-1:0]]);
        end else begin
            host_rdata <= '0;
        end
    end
endmodule

// File: rtl/pulse_ring_logger.sv
// Top level: synchroniser, interval timer and record store for one pulse pin.
// Assumes CNT_W <= 32 and DEPTH < 2**IDX_W.
module pulse_ring_logger
    import pulse_ring_pkg::*;
#(
    parameter  int DEPTH       = 300,
    parameter  int CNT_W       = 32,
    parameter  int IDX_W       = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(2 * DEPTH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [IDX_W-1:0]  host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic             rise, fall;
    logic             rec_valid;
    logic [CNT_W-1:0] rec_lo, rec_hi;

    pulse_ring_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pulse_in), .rise(rise), .fall(fall)
    );

    pulse_ring_interval #(.CNT_W(CNT_W)) u_int (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .rec_valid(rec_valid), .rec_lo(rec_lo), .rec_hi(rec_hi)
    );

    pulse_ring_store #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_lo(rec_lo), .rec_hi(rec_hi),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );
endmodule

// File: rtl/pulse_ring_logger_checker.sv
// Temporal checks on the pulse ring logger, bound into every instance.
module pulse_ring_logger_checker
    import pulse_ring_pkg::*;
#(
    parameter int DEPTH  = 300,
    parameter int CNT_W  = 32,
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              edge_any,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              rec_valid,
    input wr_step_e          wstep,
    input logic [IDX_W-1:0]  tail_q,
    input logic [IDX_W-1:0]  head_q
);
    AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tail_q < IDX_W'(DEPTH)); // R8

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tail_q) |-> tail_q == (($past(tail_q) == IDX_W'(DEPTH - 1)) ? '0 : $past(tail_q) + IDX_W'(1))); // R8

    AST_TAIL_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tail_q) |-> $past(wstep) == WR_HI); // R7

    AST_NO_RECORD_IN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> wstep != WR_LO); // R7

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) && !edge_any |=> cnt_q == '1); // R6

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_addr == '0) |=> $stable(head_q)); // R10

    AST_READ_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == ADDR_W'(1) |=> host_rdata == DATA_W'($past(tail_q))); // R9
endmodule

bind pulse_ring_logger pulse_ring_logger_checker #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_rdata(host_rdata), .edge_any(rise | fall), .cnt_q(u_int.cnt_q),
    .rec_valid(rec_valid), .wstep(u_store.wstep), .tail_q(u_store.tail_q),
    .head_q(u_store.head_q)
);

// File: tb/pulse_ring_logger_test.sv
// Bench: behavioural reference model compared with host_rdata on every clock.
module pulse_ring_logger_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 5;
    localparam int CNT_W  = 8;
    localparam int IDX_W  = 16;
    localparam int ADDR_W = $clog2(2 * DEPTH + 2);
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pulse_in = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [IDX_W-1:0]  host_wdata = '0;
    logic [31:0]       host_rdata;

    pulse_ring_logger #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    vectors = 0, fails = 0;
    bit    done = 1'b0, live = 1'b0;
    string cur_req = "R1";

    // reference model state
    int  d1, d2, d3, cnt_m, st_m, lo_hold, plo, phi, wstep_m, tail_m, head_m;
    int  lo_m [DEPTH];
    int  hi_m [DEPTH];
    bit  full_m [DEPTH];
    logic [31:0] exp_rdata = '0;

    function automatic logic [31:0] decode(int a);
        int k;
        if (a == 0) return 32'(head_m);
        if (a == 1) return 32'(tail_m);
        k = (a - 2) / 2;
        if (k >= DEPTH || !full_m[k]) return 0;
        return ((a - 2) % 2 == 0) ? 32'(lo_m[k]) : 32'(hi_m[k]);
    endfunction

    always @(posedge clk) begin : model
        bit r, f;
        int v;
        if (!rst_n) begin
            d1 = 0; d2 = 0; d3 = 0; cnt_m = 0; st_m = 0; lo_hold = 0;
            plo = 0; phi = 0; wstep_m = 0; tail_m = 0; head_m = 0;
            foreach (full_m[i]) full_m[i] = 0;
            exp_rdata = 0;
        end else begin
            exp_rdata = decode(int'(host_addr));
            r = (d2 == 1) && (d3 == 0);
            f = (d2 == 0) && (d3 == 1);
            v = cnt_m;
            if (wstep_m == 2) begin
                hi_m[tail_m] = phi; full_m[tail_m] = 1;
                tail_m = (tail_m + 1) % DEPTH; wstep_m = 0;
            end else if (wstep_m == 1) begin
                lo_m[tail_m] = plo; wstep_m = 2;
            end
            if (r || f) cnt_m = 1;
            else if (cnt_m < MAXC) cnt_m++;
            case (st_m)
                0: if (f) st_m = 1;
                1: if (r) begin lo_hold = v; st_m = 2; end
                default: if (f) begin plo = lo_hold; phi = v; wstep_m = 1; st_m = 1; end
            endcase
            if (host_we && host_addr == '0) head_m = int'(host_wdata);
            d3 = d2; d2 = d1; d1 = int'(pulse_in);
        end
        live = 1'b1;
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            vectors++;
            if (host_rdata !== exp_rdata) begin
                fails++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", cur_req, host_addr, host_rdata, exp_rdata);
            end
        end
    end

    task automatic tick(input bit lvl);
        @(negedge clk);
        pulse_in  = lvl;
        host_we   = 1'b0;
        host_addr = host_addr + 1'b1;
    endtask

    task automatic hold(input bit lvl, input int n);
        repeat (n) tick(lvl);
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = ADDR_W'(a);
        host_wdata = IDX_W'(d);
    endtask

    initial begin
        cur_req = "R1";                     // reset state reads zero
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hold(0, 16);
        cur_req = "R3";                     // early rise ignored, first fall arms
        hold(1, 20); hold(0, 13);
        cur_req = "R4/R5";                  // ordinary low/high pairs
        hold(1, 37); hold(0, 21); hold(1, 9); hold(0, 14);
        cur_req = "R2/R7";                  // one-clock pulses, back-to-back writes
        for (int i = 0; i < 6; i++) begin hold(1, 1); hold(0, 1); end
        cur_req = "R8";                     // enough records to wrap the ring
        for (int i = 0; i < 7; i++) begin hold(1, 3 + i); hold(0, 5 + 2 * i); end
        cur_req = "R6";                     // intervals past the counter range
        hold(1, 300); hold(0, 270); hold(1, 4); hold(0, 6);
        cur_req = "R10";                    // head write, ignored writes elsewhere
        host_write(0, 16'h1234); host_write(1, 16'h00aa); host_write(5, 16'h5555);
        hold(0, 20);
        cur_req = "R9";                     // final address sweep
        hold(0, 40);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule